// File: doc/BRIEF.md
# Flash Mapping Repair Sequencer

This block is the recovery engine that a data-flash controller starts after its logical-to-physical map rebuild has aborted. It walks the physical pages of one sector three times. The first sweep reads each page at the normal read threshold and erases every page that comes back faulty. The second sweep does the same at a tighter soft threshold. The third sweep rebuilds a per-logical-page tally of which physical pages claim each logical page.

When exactly one logical page is claimed twice, the sequencer reads both claimants at the hard threshold and erases the one with worse signal quality. If the quality is equal, it uses a cyclic three-state age counter and erases the older page. Every repair is a page erase, issued over a request/acknowledge handshake. At the end the block publishes an 8-bit status word that combines the sector number with a two-bit outcome code.

Flash reads are also a handshake. A request carries a page number and a read mode (user, soft, hard). The reply, returned with the acknowledge, carries a faulty flag, a mapped flag, the logical page link, the age counter and a quality figure.

Top module: `flash_map_repair`

## Requirements
- R1: After reset, `status` is 0x00, `busy` and `done` are low, and neither `rd_req` nor `er_req` is asserted.
- R2: The first sweep reads physical pages 0 up to NPHYS-1 in ascending order in user mode (`rd_mode`=0). Every page replied as faulty is erased before the next page is read, with no limit on the number of erases.
- R3: The second sweep reads every physical page in soft mode (`rd_mode`=1), exactly once each, and erases every page replied as faulty.
- R4: The third sweep reads in user mode starting at page NPHYS-1, then pages 0 up to NPHYS-2. It tallies each mapped, non-faulty page under its logical link.
- R5: If two or more logical pages are claimed at least twice, or any logical page is claimed three or more times, nothing is erased after the sweeps and the outcome is unresolved.
- R6: With exactly one doubly claimed logical page, both claimants are read in hard mode (`rd_mode`=2). The page with the lower `rd_quality` value is erased.
- R7: With equal quality, the age counters decide. The cycle is 1→2→3→1, the newer value is the successor of the other, and the older page is erased.
- R8: With equal quality and equal age values, nothing is erased and the outcome is unresolved.
- R9: With equal quality, an age value of 0 marks its page as faulty and that page is erased. If both ages are 0, the outcome is unresolved.
- R10: At completion, `status[4:0]` is the sector number captured at start and `status[5]` is 0. `status[7:6]` is 0 for zero or one erase, 1 for two or more erases (the count saturates at 2), and 2 for unresolved; unresolved takes precedence.
- R11: `er_req` and `er_page` hold until `er_done`, and no read is requested while an erase is pending. `rd_req` and `rd_page` hold until `rd_ack`.
- R12: `done` pulses high for exactly one cycle at completion, while `busy` is low. `status` keeps its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a repair run when idle |
| sector | input | 5 | Sector number reported in the status word |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | {outcome[1:0], 1'b0, sector[4:0]} |
| rd_req | output | 1 | Page read request |
| rd_page | output | $clog2(NPHYS) | Physical page to read |
| rd_mode | output | 2 | 0 user, 1 soft, 2 hard threshold |
| rd_ack | input | 1 | Read reply valid |
| rd_faulty | input | 1 | Page faulty at the requested threshold |
| rd_mapped | input | 1 | Page holds a logical link |
| rd_lpage | input | $clog2(NLOG) | Logical page link |
| rd_age | input | 2 | Cyclic age counter of the page |
| rd_quality | input | QW | Hard-read quality, higher is better |
| er_req | output | 1 | Page erase request |
| er_page | output | $clog2(NPHYS) | Physical page to erase |
| er_done | input | 1 | Erase finished |

## Verification
A corrupted page index or pass state shows up within one read handshake as a read of the wrong page or in the wrong mode. It also changes how many soft-mode reads a run issues and which page opens the third sweep. A tally or judge fault appears only at the end of the run: the wrong page is erased, or no page is, and the outcome bits in `status` carry the wrong code. A mistake in the repair counter shows up only in a run with two or more erases, as outcome 0 where 1 was due.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    typedef enum logic [1:0] {
        RM_USER = 2'd0,
        RM_SOFT = 2'd1,
        RM_HARD = 2'd2
    } rd_mode_e;

    typedef enum logic [1:0] {
        OC_CLEAN = 2'd0,
        OC_MULTI = 2'd1,
        OC_UNRES = 2'd2
    } outcome_e;

    typedef enum logic [1:0] {
        PS_USER,
        PS_SOFT,
        PS_SCAN,
        PS_FIX
    } pass_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD,
        S_ER,
        S_NEXT,
        S_EVAL,
        S_HRD_A,
        S_HRD_B,
        S_FIX,
        S_FIN
    } state_e;

    typedef struct packed {
        outcome_e   oc;
        logic       rsvd;
        logic [4:0] sector;
    } status_t;

    // successor in the 1 -> 2 -> 3 -> 1 age cycle; 0 has none
    function automatic logic [1:0] age_succ(input logic [1:0] a);
        case (a)
            2'd1:    return 2'd2;
            2'd2:    return 2'd3;
            2'd3:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/mrs_map_tally.sv
module mrs_map_tally #(
    parameter int NPHYS = 33,
    parameter int NLOG  = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     load,
    input  logic [$clog2(NLOG)-1:0]  lpage,
    input  logic [$clog2(NPHYS)-1:0] ppage,
    output logic [1:0]               n_dup,
    output logic                     multi_hit,
    output logic [$clog2(NPHYS)-1:0] dup_pa,
    output logic [$clog2(NPHYS)-1:0] dup_pb
);
    localparam int PW = $clog2(NPHYS);

    logic [1:0]    cnt   [NLOG];
    logic [PW-1:0] first [NLOG];
    logic [PW-1:0] second[NLOG];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < NLOG; i++) cnt[i] <= 2'd0;
        end else if (load) begin
            case (cnt[lpage])
                2'd0: begin first[lpage]  <= ppage; cnt[lpage] <= 2'd1; end
                2'd1: begin second[lpage] <= ppage; cnt[lpage] <= 2'd2; end
                default: cnt[lpage] <= 2'd3;
            endcase
        end
    end

    always_comb begin
        n_dup     = 2'd0;
        multi_hit = 1'b0;
        dup_pa    = '0;
        dup_pb    = '0;
        for (int i = 0; i < NLOG; i++) begin
            if (cnt[i] >= 2'd2) begin
                if (n_dup != 2'd2) n_dup = n_dup + 2'd1;
                dup_pa = first[i];
                dup_pb = second[i];
            end
            if (cnt[i] == 2'd3) multi_hit = 1'b1;
        end
    end

    // a logical entry never counts down while loading
    assert_tally_mono_R5: assert property (@(posedge clk) disable iff (rst)
        (load && !clr) |=> (cnt[$past(lpage)] != 2'd0));

endmodule

// File: rtl/mrs_age_judge.sv
module mrs_age_judge #(
    parameter int QW = 4
) (
    input  logic [QW-1:0] qa,
    input  logic [QW-1:0] qb,
    input  logic [1:0]    ca,
    input  logic [1:0]    cb,
    output logic          unres,
    output logic          erase_b
);
    import mrs_pkg::*;

    always_comb begin
        unres   = 1'b0;
        erase_b = 1'b0;
        if (qa < qb) begin
            erase_b = 1'b0;
        end else if (qa > qb) begin
            erase_b = 1'b1;
        end else if (ca == 2'd0 && cb == 2'd0) begin
            unres = 1'b1;
        end else if (ca == 2'd0) begin
            erase_b = 1'b0;
        end else if (cb == 2'd0) begin
            erase_b = 1'b1;
        end else if (ca == cb) begin
            unres = 1'b1;
        end else if (age_succ(ca) == cb) begin
            erase_b = 1'b0;
        end else begin
            erase_b = 1'b1;
        end
    end

endmodule

// File: rtl/mrs_status_pack.sv
module mrs_status_pack (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       bump,
    input  logic       fin,
    input  logic       unres,
    input  logic [4:0] sector,
    output logic [7:0] status
);
    import mrs_pkg::*;

    logic [1:0] repairs;
    status_t    stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            repairs <= 2'd0;
            stat_q  <= '0;
        end else begin
            if (clr)
                repairs <= 2'd0;
            else if (bump && repairs != 2'd2)
                repairs <= repairs + 2'd1;
            if (fin) begin
                stat_q.sector <= sector;
                stat_q.rsvd   <= 1'b0;
                stat_q.oc     <= unres ? OC_UNRES :
                                 (repairs == 2'd2) ? OC_MULTI : OC_CLEAN;
            end
        end
    end

    assign status = stat_q;

    assert_outcome_code_R10: assert property (@(posedge clk) disable iff (rst)
        (status[7:6] != 2'b11) && (status[5] == 1'b0));
    assert_repair_sat_R10: assert property (@(posedge clk) disable iff (rst)
        repairs <= 2'd2);

endmodule

// File: rtl/flash_map_repair.sv
module flash_map_repair #(
    parameter int NPHYS = 33,
    parameter int NLOG  = 32,
    parameter int QW    = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [4:0]               sector,
    output logic                     busy,
    output logic                     done,
    output logic [7:0]               status,
    output logic                     rd_req,
    output logic [$clog2(NPHYS)-1:0] rd_page,
    output logic [1:0]               rd_mode,
    input  logic                     rd_ack,
    input  logic                     rd_faulty,
    input  logic                     rd_mapped,
    input  logic [$clog2(NLOG)-1:0]  rd_lpage,
    input  logic [1:0]               rd_age,
    input  logic [QW-1:0]            rd_quality,
    output logic                     er_req,
    output logic [$clog2(NPHYS)-1:0] er_page,
    input  logic                     er_done
);
    import mrs_pkg::*;

    localparam int PW = $clog2(NPHYS);
    localparam logic [PW-1:0] LAST = PW'(NPHYS - 1);

    state_e        state;
    pass_e         pass;
    logic [PW-1:0] idx, pa, pb, er_tgt, cur_page;
    logic [QW-1:0] qa, qb;
    logic [1:0]    ca, cb;
    logic          unres, done_q;
    logic [4:0]    sector_q;

    logic [1:0]    n_dup;
    logic          multi_hit, j_unres, j_erase_b;
    logic [PW-1:0] dup_pa, dup_pb;
    logic          run_clr, tally_load;

    assign cur_page   = (pass == PS_SCAN) ? ((idx == '0) ? LAST : idx - PW'(1)) : idx;
    assign run_clr    = (state == S_IDLE) && start;
    assign tally_load = (state == S_RD) && rd_ack && (pass == PS_SCAN) && rd_mapped && !rd_faulty;

    mrs_map_tally #(.NPHYS(NPHYS), .NLOG(NLOG)) u_tally (
        .clk(clk), .rst(rst), .clr(run_clr), .load(tally_load),
        .lpage(rd_lpage), .ppage(cur_page),
        .n_dup(n_dup), .multi_hit(multi_hit), .dup_pa(dup_pa), .dup_pb(dup_pb)
    );

    mrs_age_judge #(.QW(QW)) u_judge (
        .qa(qa), .qb(qb), .ca(ca), .cb(cb), .unres(j_unres), .erase_b(j_erase_b)
    );

    mrs_status_pack u_stat (
        .clk(clk), .rst(rst), .clr(run_clr),
        .bump((state == S_ER) && er_done),
        .fin(state == S_FIN), .unres(unres), .sector(sector_q),
        .status(status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            pass     <= PS_USER;
            idx      <= '0;
            pa       <= '0;
            pb       <= '0;
            er_tgt   <= '0;
            qa       <= '0;
            qb       <= '0;
            ca       <= 2'd0;
            cb       <= 2'd0;
            unres    <= 1'b0;
            done_q   <= 1'b0;
            sector_q <= 5'd0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    pass     <= PS_USER;
                    idx      <= '0;
                    unres    <= 1'b0;
                    sector_q <= sector;
                    state    <= S_RD;
                end
                S_RD: if (rd_ack) begin
                    if (pass != PS_SCAN && rd_faulty) begin
                        er_tgt <= cur_page;
                        state  <= S_ER;
                    end else begin
                        state <= S_NEXT;
                    end
                end
                S_ER: if (er_done) begin
                    state <= (pass == PS_FIX) ? S_FIN : S_NEXT;
                end
                S_NEXT: begin
                    if (idx == LAST) begin
                        idx <= '0;
                        case (pass)
                            PS_USER: begin pass <= PS_SOFT; state <= S_RD; end
                            PS_SOFT: begin pass <= PS_SCAN; state <= S_RD; end
                            default: state <= S_EVAL;
                        endcase
                    end else begin
                        idx   <= idx + PW'(1);
                        state <= S_RD;
                    end
                end
                S_EVAL: begin
                    if (n_dup == 2'd0) begin
                        state <= S_FIN;
                    end else if (n_dup != 2'd1 || multi_hit) begin
                        unres <= 1'b1;
                        state <= S_FIN;
                    end else begin
                        pa    <= dup_pa;
                        pb    <= dup_pb;
                        pass  <= PS_FIX;
                        state <= S_HRD_A;
                    end
                end
                S_HRD_A: if (rd_ack) begin
                    qa    <= rd_quality;
                    ca    <= rd_age;
                    state <= S_HRD_B;
                end
                S_HRD_B: if (rd_ack) begin
                    qb    <= rd_quality;
                    cb    <= rd_age;
                    state <= S_FIX;
                end
                S_FIX: begin
                    if (j_unres) begin
                        unres <= 1'b1;
                        state <= S_FIN;
                    end else begin
                        er_tgt <= j_erase_b ? pb : pa;
                        state  <= S_ER;
                    end
                end
                S_FIN: begin
                    done_q <= 1'b1;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy    = (state != S_IDLE);
    assign done    = done_q;
    assign rd_req  = (state == S_RD) || (state == S_HRD_A) || (state == S_HRD_B);
    assign rd_page = (state == S_HRD_A) ? pa : (state == S_HRD_B) ? pb : cur_page;
    assign rd_mode = (state == S_HRD_A || state == S_HRD_B) ? RM_HARD :
                     (pass == PS_SOFT) ? RM_SOFT : RM_USER;
    assign er_req  = (state == S_ER);
    assign er_page = er_tgt;

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_page)));
    assert_er_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (er_req && !er_done) |=> (er_req && $stable(er_page)));
    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && er_req));
    assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !rd_req && !er_req));
    assert_page_range_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_req || er_req) |-> (rd_page <= LAST && er_page <= LAST));

endmodule

// File: tb/sim_flash_map_repair.sv
module sim_flash_map_repair;
    localparam int NP = 33;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [4:0] sector = 5'd0;
    logic       busy, done, rd_req, er_req;
    logic [7:0] status;
    logic [5:0] rd_page, er_page;
    logic [1:0] rd_mode;
    logic       rd_ack = 1'b0, rd_faulty = 1'b0, rd_mapped = 1'b0, er_done = 1'b0;
    logic [4:0] rd_lpage = 5'd0;
    logic [1:0] rd_age = 2'd0;
    logic [3:0] rd_quality = 4'd0;

    always #10 clk = ~clk;

    flash_map_repair u0 (
        .clk(clk), .rst(rst), .start(start), .sector(sector),
        .busy(busy), .done(done), .status(status),
        .rd_req(rd_req), .rd_page(rd_page), .rd_mode(rd_mode),
        .rd_ack(rd_ack), .rd_faulty(rd_faulty), .rd_mapped(rd_mapped),
        .rd_lpage(rd_lpage), .rd_age(rd_age), .rd_quality(rd_quality),
        .er_req(er_req), .er_page(er_page), .er_done(er_done)
    );

    // flash page model
    logic       cfg_map [NP];
    logic [4:0] cfg_lp  [NP];
    logic [1:0] cfg_age [NP];
    logic [3:0] cfg_q   [NP];
    logic       cfg_fu  [NP];
    logic       cfg_fs  [NP];
    logic       wiped   [NP];
    logic       mdl_clr = 1'b0;
    int n_soft, n_hard, scan_first, er_cnt, overlap;
    int er_list [8];

    always @(posedge clk) begin
        if (mdl_clr) begin
            for (int i = 0; i < NP; i++) wiped[i] <= 1'b0;
            n_soft <= 0; n_hard <= 0; scan_first <= -1; er_cnt <= 0; overlap <= 0;
            rd_ack <= 1'b0; er_done <= 1'b0;
        end else begin
            rd_ack  <= rd_req && !rd_ack;
            er_done <= er_req && !er_done;
            if (rd_req && er_req) overlap <= overlap + 1;
            if (rd_req && !rd_ack) begin
                rd_mapped  <= cfg_map[rd_page] && !wiped[rd_page];
                rd_lpage   <= cfg_lp[rd_page];
                rd_age     <= cfg_age[rd_page];
                rd_quality <= cfg_q[rd_page];
                case (rd_mode)
                    2'd0: rd_faulty <= cfg_fu[rd_page] && !wiped[rd_page];
                    2'd1: rd_faulty <= (cfg_fu[rd_page] || cfg_fs[rd_page]) && !wiped[rd_page];
                    default: rd_faulty <= 1'b0;
                endcase
                if (rd_mode == 2'd1) n_soft <= n_soft + 1;
                if (rd_mode == 2'd2) n_hard <= n_hard + 1;
                if (rd_mode == 2'd0 && n_soft == NP && scan_first < 0) scan_first <= int'(rd_page);
            end
            if (er_req && !er_done) begin
                wiped[er_page] <= 1'b1;
                if (er_cnt < 8) er_list[er_cnt] <= int'(er_page);
                er_cnt <= er_cnt + 1;
            end
        end
    end

    int checks = 0, failures = 0;
    bit timed_out = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_default();
        for (int i = 0; i < NP; i++) begin
            cfg_map[i] = (i < 32);
            cfg_lp[i]  = 5'(i);
            cfg_age[i] = 2'd1;
            cfg_q[i]   = 4'd8;
            cfg_fu[i]  = 1'b0;
            cfg_fs[i]  = 1'b0;
        end
    endtask

    task automatic run(input logic [4:0] sec);
        int n = 0;
        @(negedge clk) mdl_clr = 1'b1;
        @(negedge clk) mdl_clr = 1'b0;
        sector = sec;
        start  = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            timed_out = 1;
            chk(0, "R12 run timeout", n, 0);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(status == 8'h00, "R1 status at reset", status, 0);
        chk({busy, done, rd_req, er_req} == 4'b0, "R1 idle outputs", {busy, done, rd_req, er_req}, 0);
    endtask

    task automatic t_clean();
        set_default();
        run(5'h13);
        chk(status == 8'h13, "R10 clean status", status, 8'h13);
        chk(er_cnt == 0, "R2 no erase when clean", er_cnt, 0);
        chk(n_soft == NP, "R3 soft read count", n_soft, NP);
        chk(scan_first == NP - 1, "R4 scan starts at last page", scan_first, NP - 1);
        chk(n_hard == 0, "R6 no hard read without duplicate", n_hard, 0);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R12 done is one pulse", done, 0);
        chk(status == 8'h13, "R12 status kept", status, 8'h13);
    endtask

    task automatic t_faults();
        set_default();
        cfg_fu[3] = 1'b1; cfg_fu[20] = 1'b1; cfg_fs[7] = 1'b1;
        run(5'h05);
        chk(er_cnt == 3, "R2 erase count", er_cnt, 3);
        chk(er_list[0] == 3 && er_list[1] == 20, "R2 user-pass erase order",
            er_list[0] * 256 + er_list[1], 3 * 256 + 20);
        chk(er_list[2] == 7, "R3 soft-pass erase", er_list[2], 7);
        chk(status == 8'h45, "R10 multi outcome", status, 8'h45);
        chk(overlap == 0, "R11 no read during erase", overlap, 0);
    endtask

    task automatic t_one_fault();
        set_default();
        cfg_fu[10] = 1'b1;
        run(5'h1F);
        chk(er_cnt == 1 && er_list[0] == 10, "R2 single erase", er_list[0], 10);
        chk(status == 8'h1F, "R10 single-fix outcome", status, 8'h1F);
    endtask

    task automatic t_dup_quality();
        set_default();
        cfg_map[32] = 1'b1; cfg_lp[32] = 5'd4; cfg_q[32] = 4'd9; cfg_q[4] = 4'd5;
        run(5'h0B);
        chk(n_hard == 2, "R6 two hard reads", n_hard, 2);
        chk(er_cnt == 1 && er_list[0] == 4, "R6 lower quality erased", er_list[0], 4);
        chk(status == 8'h0B, "R6 status", status, 8'h0B);
    endtask

    task automatic t_dup_age();
        set_default();
        cfg_map[32] = 1'b1; cfg_lp[32] = 5'd4; cfg_age[32] = 2'd1; cfg_age[4] = 2'd3;
        run(5'h02);
        chk(er_cnt == 1 && er_list[0] == 4, "R7 age 3 older than 1", er_list[0], 4);
        set_default();
        cfg_map[32] = 1'b1; cfg_lp[32] = 5'd4; cfg_age[32] = 2'd1; cfg_age[4] = 2'd2;
        run(5'h02);
        chk(er_cnt == 1 && er_list[0] == 32, "R7 age 1 older than 2", er_list[0], 32);
    endtask

    task automatic t_dup_equal();
        set_default();
        cfg_map[32] = 1'b1; cfg_lp[32] = 5'd4; cfg_age[32] = 2'd2; cfg_age[4] = 2'd2;
        run(5'h01);
        chk(er_cnt == 0, "R8 no erase on equal age", er_cnt, 0);
        chk(status == 8'h81, "R8 unresolved", status, 8'h81);
    endtask

    task automatic t_age_zero();
        set_default();
        cfg_map[32] = 1'b1; cfg_lp[32] = 5'd4; cfg_age[32] = 2'd0; cfg_age[4] = 2'd2;
        run(5'h03);
        chk(er_cnt == 1 && er_list[0] == 32, "R9 zero age erased", er_list[0], 32);
        set_default();
        cfg_map[32] = 1'b1; cfg_lp[32] = 5'd4; cfg_age[32] = 2'd0; cfg_age[4] = 2'd0;
        run(5'h03);
        chk(er_cnt == 0 && status == 8'h83, "R9 both zero unresolved", status, 8'h83);
    endtask

    task automatic t_multi_dup();
        set_default();
        cfg_map[32] = 1'b1; cfg_lp[32] = 5'd4; cfg_lp[5] = 5'd6;
        run(5'h06);
        chk(er_cnt == 0 && n_hard == 0, "R5 two duplicates untouched", er_cnt, 0);
        chk(status == 8'h86, "R5 two duplicates unresolved", status, 8'h86);
        set_default();
        cfg_map[32] = 1'b1; cfg_lp[32] = 5'd4; cfg_lp[5] = 5'd4;
        run(5'h07);
        chk(er_cnt == 0 && status == 8'h87, "R5 triple unresolved", status, 8'h87);
    endtask

    task automatic t_saturate();
        set_default();
        cfg_fu[1] = 1'b1; cfg_fu[2] = 1'b1; cfg_fu[3] = 1'b1;
        cfg_map[32] = 1'b1; cfg_lp[32] = 5'd9; cfg_q[9] = 4'd2;
        run(5'h10);
        chk(er_cnt == 4 && er_list[3] == 9, "R10 four repairs", er_cnt, 4);
        chk(status == 8'h50, "R10 saturated multi outcome", status, 8'h50);
    endtask

    initial begin
        #4000000;
        timed_out = 1;
        chk(0, "R12 watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        if (!timed_out) t_clean();
        if (!timed_out) t_faults();
        if (!timed_out) t_one_fault();
        if (!timed_out) t_dup_quality();
        if (!timed_out) t_dup_age();
        if (!timed_out) t_dup_equal();
        if (!timed_out) t_age_zero();
        if (!timed_out) t_multi_dup();
        if (!timed_out) t_saturate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule